// File: doc/BRIEF.md
# Frame-Synchronous Double-Banked Channel Buffer Set

This block sits between a byte-oriented data mover and two serial line interfaces (a subscriber line port and a PCM highway port). Both interfaces run on a fixed 125 µs frame. The block holds four independent buffers: line transmit, line receive, PCM transmit and PCM receive. Each buffer keeps two banks of one byte per channel. A single-cycle frame strobe swaps the roles of the two banks. During a frame, the producing side fills one bank while the consuming side reads the bank that was filled during the previous frame. Latency through any buffer is therefore exactly one whole frame, whatever the cycle in which the byte arrived.

In the transmit buffers, the mover writes and the interface reads. In the receive buffers, the interface writes and the mover reads. A mode input places a third, hold bank in both transmit paths. The hold bank copies the outgoing frame at each strobe and delays transmission by one more frame, which leaves room for a conference summation pass elsewhere. A direct PCM-to-line connection is built by the mover itself: it reads the PCM receive buffer and writes the line transmit buffer, which gives two frames of delay from capture to transmission.

Top module: `frame_switch_buffers`

## Requirements
- R1: After reset, every read port (line TX out, PCM TX out, both mover receive reads) returns the idle value 0xFF for every channel until data has passed through.
- R2: With conf_en low, a byte the mover writes to a transmit buffer during frame N is presented on that interface's output for its channel during all of frame N+1.
- R3: A byte the interface writes into a receive buffer during frame N is returned to the mover for its channel during all of frame N+1.
- R4: A channel slot not written during the previous frame reads 0xFF, so no stale byte from an older frame reappears.
- R5: A write in the same clock cycle as frame_stb belongs to the frame that the strobe starts. It appears after the following strobe, not at the one it coincides with.
- R6: If one channel slot is written several times within a frame, the last write is the value delivered.
- R7: With conf_en high, both transmit paths deliver a byte written in frame N during frame N+2 instead of N+1. The receive paths are unaffected.
- R8: A mover that copies from the PCM receive read port into the line transmit buffer gives a byte captured in frame 1 on the line output in frame 3.
- R9: The four buffers and the 32 channels (5-bit channel index) are independent. A write to one slot is never visible on another buffer or channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | Single-cycle frame boundary pulse |
| conf_en | input | 1 | Inserts the extra transmit frame stage |
| mv_lt_we | input | 1 | Mover write enable, line TX buffer |
| mv_lt_ch | input | 5 | Mover write channel, line TX buffer |
| mv_lt_wdata | input | 8 | Mover write byte, line TX buffer |
| ln_tx_ch | input | 5 | Line interface transmit channel |
| ln_tx_data | output | 8 | Line interface transmit byte |
| ln_rx_we | input | 1 | Line interface receive write enable |
| ln_rx_ch | input | 5 | Line interface receive channel |
| ln_rx_data | input | 8 | Line interface received byte |
| mv_lr_ch | input | 5 | Mover read channel, line RX buffer |
| mv_lr_rdata | output | 8 | Mover read byte, line RX buffer |
| mv_pt_we | input | 1 | Mover write enable, PCM TX buffer |
| mv_pt_ch | input | 5 | Mover write channel, PCM TX buffer |
| mv_pt_wdata | input | 8 | Mover write byte, PCM TX buffer |
| pcm_tx_ch | input | 5 | PCM interface transmit channel |
| pcm_tx_data | output | 8 | PCM interface transmit byte |
| pcm_rx_we | input | 1 | PCM interface receive write enable |
| pcm_rx_ch | input | 5 | PCM interface receive channel |
| pcm_rx_data | input | 8 | PCM interface received byte |
| mv_pr_ch | input | 5 | Mover read channel, PCM RX buffer |
| mv_pr_rdata | output | 8 | Mover read byte, PCM RX buffer |

## Verification
The hardest case to reach is a write that lands in the same clock cycle as the frame strobe. The strobe and the write enable must rise together, and the byte must then be shown absent for one whole frame and present in the next. The stimulus drives both inputs at one falling edge and then checks across two further strobes. The conference stage is similar. Its one-frame hold only shows when conf_en is raised between strobes, with writes in that frame, so the bench observes an idle frame followed by the data in both transmit paths while a receive byte written in the same frame arrives one frame earlier.

// File: rtl/swb_pkg.sv
// Package: shared constants and role type for the frame switching buffers.
// Assumes: none; pure declarations.
package swb_pkg;

    // Which side of a buffer the mover sits on; decides whether a hold stage exists.
    typedef enum logic {
        ROLE_TX = 1'b0,   // mover writes, interface reads
        ROLE_RX = 1'b1    // interface writes, mover reads
    } swb_role_e;

    localparam int DEF_NCH = 32;
    localparam int DEF_DW  = 8;

endpackage

// File: rtl/swb_bank.sv
// Module: one bank of one-byte-per-channel storage with per-slot valid flags.
// A slot whose flag is clear reads as all ones (idle). A clear and a write
// in the same cycle leave only the written slot valid.
// Assumes: wch and rch are below NCH.
module swb_bank #(
    parameter int NCH = 32,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [CW-1:0]     wch,
    input  logic [DW-1:0]     wdata,
    input  logic [CW-1:0]     rch,
    output logic [DW-1:0]     rdata,
    output logic [NCH*DW-1:0] all_data,
    output logic [NCH-1:0]    all_vld
);

    logic [DW-1:0]  mem [NCH];
    logic [NCH-1:0] vld_q;

    // Valid flags: wiped on clear, set by a write (write applied after clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clr) vld_q <= '0;
            if (we)  vld_q[wch] <= 1'b1;
        end
    end

    // Data storage: plain write port, no reset needed behind the flags.
    always_ff @(posedge clk) begin
        if (we) mem[wch] <= wdata;
    end

    // Read port: idle pattern for empty slots.
    always_comb begin
        rdata = vld_q[rch] ? mem[rch] : {DW{1'b1}};
    end

    // Whole-bank export for the hold stage.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_flat
            assign all_data[g*DW +: DW] = mem[g];
        end
    endgenerate
    assign all_vld = vld_q;

endmodule

// File: rtl/swb_hold.sv
// Module: frame hold bank. On load it copies an entire bank (data and flags),
// giving one extra frame of delay on the transmit path.
// Assumes: load is the frame strobe; inputs are the bank being released.
module swb_hold #(
    parameter int NCH = 32,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCH*DW-1:0] in_data,
    input  logic [NCH-1:0]    in_vld,
    input  logic [CW-1:0]     rch,
    output logic [DW-1:0]     rdata
);

    logic [NCH*DW-1:0] data_q;
    logic [NCH-1:0]    vld_q;

    // Flags: cleared by reset, replaced wholesale at each load.
    always_ff @(posedge clk) begin
        if (!rst_n)    vld_q <= '0;
        else if (load) vld_q <= in_vld;
    end

    // Data: captured wholesale at each load.
    always_ff @(posedge clk) begin
        if (load) data_q <= in_data;
    end

    // Read port with idle pattern.
    always_comb begin
        rdata = vld_q[rch] ? data_q[rch*DW +: DW] : {DW{1'b1}};
    end

endmodule

// File: rtl/swb_pingpong.sv
// Module: two-bank switching buffer. The bank pointer flips at each frame
// strobe; the writer always uses the bank the pointer selects after any flip
// in the current cycle, the reader uses the other one. The bank handed to
// the writer is emptied at the flip. For ROLE_TX a hold bank can add one
// frame of delay when conf_en is high.
// Assumes: frame_stb is a single-cycle pulse.
module swb_pingpong
    import swb_pkg::*;
#(
    parameter int        NCH  = 32,
    parameter int        DW   = 8,
    parameter swb_role_e ROLE = ROLE_TX,
    localparam int       CW   = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          conf_en,
    input  logic          we,
    input  logic [CW-1:0] wch,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] rch,
    output logic [DW-1:0] rdata
);

    logic              sel_q;
    logic              sel_now;
    logic [DW-1:0]     bank_rd  [2];
    logic [NCH*DW-1:0] bank_dat [2];
    logic [NCH-1:0]    bank_vld [2];
    logic [DW-1:0]     direct_rd;

    // Effective writer bank this cycle, including a flip on the strobe.
    assign sel_now = frame_stb ? ~sel_q : sel_q;

    // Bank pointer: flips once per frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_now;
    end

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            swb_bank #(.NCH(NCH), .DW(DW)) bank_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (frame_stb && (sel_now == 1'(b))),
                .we       (we && (sel_now == 1'(b))),
                .wch      (wch),
                .wdata    (wdata),
                .rch      (rch),
                .rdata    (bank_rd[b]),
                .all_data (bank_dat[b]),
                .all_vld  (bank_vld[b])
            );
        end
    endgenerate

    assign direct_rd = bank_rd[~sel_now];

    generate
        if (ROLE == ROLE_TX) begin : g_tx
            logic [DW-1:0] hold_rd;
            swb_hold #(.NCH(NCH), .DW(DW)) hold_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (frame_stb),
                .in_data (bank_dat[~sel_q]),
                .in_vld  (bank_vld[~sel_q]),
                .rch     (rch),
                .rdata   (hold_rd)
            );
            assign rdata = conf_en ? hold_rd : direct_rd;
        end else begin : g_rx
            logic unused_rx;
            assign unused_rx = conf_en ^ (^bank_dat[0]) ^ (^bank_dat[1])
                             ^ (^bank_vld[0]) ^ (^bank_vld[1]);
            assign rdata = direct_rd;
        end
    endgenerate

endmodule

// File: rtl/frame_switch_buffers.sv
// Module: set of four frame switching buffers (line TX/RX, PCM TX/RX)
// sharing one frame strobe and one conference-delay mode bit.
// Assumes: synchronous active-low reset; one frame strobe pulse per frame.
module frame_switch_buffers
    import swb_pkg::*;
#(
    parameter int  NCH = DEF_NCH,
    parameter int  DW  = DEF_DW,
    localparam int CW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          conf_en,
    input  logic          mv_lt_we,
    input  logic [CW-1:0] mv_lt_ch,
    input  logic [DW-1:0] mv_lt_wdata,
    input  logic [CW-1:0] ln_tx_ch,
    output logic [DW-1:0] ln_tx_data,
    input  logic          ln_rx_we,
    input  logic [CW-1:0] ln_rx_ch,
    input  logic [DW-1:0] ln_rx_data,
    input  logic [CW-1:0] mv_lr_ch,
    output logic [DW-1:0] mv_lr_rdata,
    input  logic          mv_pt_we,
    input  logic [CW-1:0] mv_pt_ch,
    input  logic [DW-1:0] mv_pt_wdata,
    input  logic [CW-1:0] pcm_tx_ch,
    output logic [DW-1:0] pcm_tx_data,
    input  logic          pcm_rx_we,
    input  logic [CW-1:0] pcm_rx_ch,
    input  logic [DW-1:0] pcm_rx_data,
    input  logic [CW-1:0] mv_pr_ch,
    output logic [DW-1:0] mv_pr_rdata
);

    // Line transmit: mover fills, line interface drains.
    swb_pingpong #(.NCH(NCH), .DW(DW), .ROLE(ROLE_TX)) line_tx_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .conf_en(conf_en),
        .we(mv_lt_we), .wch(mv_lt_ch), .wdata(mv_lt_wdata),
        .rch(ln_tx_ch), .rdata(ln_tx_data)
    );

    // Line receive: line interface fills, mover drains.
    swb_pingpong #(.NCH(NCH), .DW(DW), .ROLE(ROLE_RX)) line_rx_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .conf_en(conf_en),
        .we(ln_rx_we), .wch(ln_rx_ch), .wdata(ln_rx_data),
        .rch(mv_lr_ch), .rdata(mv_lr_rdata)
    );

    // PCM transmit: mover fills, PCM interface drains.
    swb_pingpong #(.NCH(NCH), .DW(DW), .ROLE(ROLE_TX)) pcm_tx_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .conf_en(conf_en),
        .we(mv_pt_we), .wch(mv_pt_ch), .wdata(mv_pt_wdata),
        .rch(pcm_tx_ch), .rdata(pcm_tx_data)
    );

    // PCM receive: PCM interface fills, mover drains.
    swb_pingpong #(.NCH(NCH), .DW(DW), .ROLE(ROLE_RX)) pcm_rx_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .conf_en(conf_en),
        .we(pcm_rx_we), .wch(pcm_rx_ch), .wdata(pcm_rx_data),
        .rch(mv_pr_ch), .rdata(mv_pr_rdata)
    );

endmodule

// File: rtl/frame_switch_buffers_chk.sv
// Module: port-level checker for frame_switch_buffers, attached by bind.
// Assumes: same parameters as the checked instance.
module frame_switch_buffers_chk #(
    parameter int  NCH = 32,
    parameter int  DW  = 8,
    localparam int CW  = $clog2(NCH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_stb,
    input logic          conf_en,
    input logic [CW-1:0] ln_tx_ch,
    input logic [DW-1:0] ln_tx_data,
    input logic [CW-1:0] mv_lr_ch,
    input logic [DW-1:0] mv_lr_rdata,
    input logic [DW-1:0] pcm_tx_data,
    input logic [DW-1:0] mv_pr_rdata
);

    // R1: first cycle out of reset shows idle on the line side paths.
    p_idle_reset_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ln_tx_data == {DW{1'b1}} && mv_lr_rdata == {DW{1'b1}}));

    // R1: same on the PCM side paths.
    p_idle_reset_pcm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pcm_tx_data == {DW{1'b1}} && mv_pr_rdata == {DW{1'b1}}));

    // R2: line TX output holds steady inside a frame for a fixed channel.
    p_tx_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !$past(frame_stb) && $stable(ln_tx_ch) && $stable(conf_en))
        |-> $stable(ln_tx_data));

    // R3: mover read of line RX holds steady inside a frame for a fixed channel.
    p_rx_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !$past(frame_stb) && $stable(mv_lr_ch))
        |-> $stable(mv_lr_rdata));

endmodule

bind frame_switch_buffers frame_switch_buffers_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .conf_en(conf_en),
    .ln_tx_ch(ln_tx_ch), .ln_tx_data(ln_tx_data),
    .mv_lr_ch(mv_lr_ch), .mv_lr_rdata(mv_lr_rdata),
    .pcm_tx_data(pcm_tx_data), .mv_pr_rdata(mv_pr_rdata)
);

// File: tb/frame_switch_buffers_tb_top.sv
// Scoreboard bench: the driver queues expected bytes per read port, and the
// monitor pops each item, steers the read channel and compares.
module frame_switch_buffers_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       conf_en = 1'b0;
    logic       mv_lt_we = 1'b0;  logic [4:0] mv_lt_ch = '0;  logic [7:0] mv_lt_wdata = '0;
    logic [4:0] ln_tx_ch = '0;    logic [7:0] ln_tx_data;
    logic       ln_rx_we = 1'b0;  logic [4:0] ln_rx_ch = '0;  logic [7:0] ln_rx_data = '0;
    logic [4:0] mv_lr_ch = '0;    logic [7:0] mv_lr_rdata;
    logic       mv_pt_we = 1'b0;  logic [4:0] mv_pt_ch = '0;  logic [7:0] mv_pt_wdata = '0;
    logic [4:0] pcm_tx_ch = '0;   logic [7:0] pcm_tx_data;
    logic       pcm_rx_we = 1'b0; logic [4:0] pcm_rx_ch = '0; logic [7:0] pcm_rx_data = '0;
    logic [4:0] mv_pr_ch = '0;    logic [7:0] mv_pr_rdata;

    always #5 clk = ~clk;

    frame_switch_buffers dut_i (.*);

    typedef struct {
        int         port;   // 0 line TX out, 1 line RX mover read, 2 PCM TX out, 3 PCM RX mover read
        int         ch;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    event  go_ev, done_ev;

    // Monitor: pop expected items, steer the read channel, compare.
    initial begin
        forever begin
            @(go_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.port)
                    0: ln_tx_ch  = 5'(it.ch);
                    1: mv_lr_ch  = 5'(it.ch);
                    2: pcm_tx_ch = 5'(it.ch);
                    default: mv_pr_ch = 5'(it.ch);
                endcase
                #1;
                case (it.port)
                    0: act = ln_tx_data;
                    1: act = mv_lr_rdata;
                    2: act = pcm_tx_data;
                    default: act = mv_pr_rdata;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s port=%0d ch=%0d actual=%02h expected=%02h",
                             it.req, it.port, it.ch, act, it.exp);
                end
            end
            ->done_ev;
        end
    end

    task automatic expect_b(input int port, input int ch, input logic [7:0] v, input string req);
        item_t it;
        it.port = port; it.ch = ch; it.exp = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic run_checks();
        @(negedge clk);
        ->go_ev;
        @(done_ev);
    endtask

    // Write port: 0 mover line TX, 1 line RX, 2 mover PCM TX, 3 PCM RX.
    task automatic wr(input int port, input int ch, input logic [7:0] d);
        @(negedge clk);
        case (port)
            0: begin mv_lt_we = 1; mv_lt_ch = 5'(ch); mv_lt_wdata = d; end
            1: begin ln_rx_we = 1; ln_rx_ch = 5'(ch); ln_rx_data = d; end
            2: begin mv_pt_we = 1; mv_pt_ch = 5'(ch); mv_pt_wdata = d; end
            default: begin pcm_rx_we = 1; pcm_rx_ch = 5'(ch); pcm_rx_data = d; end
        endcase
        @(negedge clk);
        mv_lt_we = 0; ln_rx_we = 0; mv_pt_we = 0; pcm_rx_we = 0;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_stb = 1;
        @(negedge clk);
        frame_stb = 0;
    endtask

    // Watchdog.
    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] copied;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: idle everywhere after reset.
        expect_b(0, 0, 8'hFF, "R1"); expect_b(0, 31, 8'hFF, "R1");
        expect_b(1, 0, 8'hFF, "R1"); expect_b(2, 5, 8'hFF, "R1");
        expect_b(3, 31, 8'hFF, "R1");
        run_checks();

        // Frame A: fill several buffers; R6 rewrite of ch3.
        wr(0, 3, 8'h11); wr(0, 31, 8'h22); wr(0, 3, 8'h33);
        wr(2, 0, 8'h44); wr(1, 5, 8'h55); wr(3, 7, 8'h66);
        expect_b(0, 3, 8'hFF, "R2");   // not visible in the writing frame
        expect_b(1, 5, 8'hFF, "R3");
        run_checks();
        strobe();

        // Frame A+1.
        expect_b(0, 3, 8'h33, "R6");
        expect_b(0, 31, 8'h22, "R2");
        expect_b(0, 4, 8'hFF, "R9");
        expect_b(2, 0, 8'h44, "R2");
        expect_b(2, 3, 8'hFF, "R9");
        expect_b(1, 5, 8'h55, "R3");
        expect_b(3, 7, 8'h66, "R3");
        expect_b(1, 7, 8'hFF, "R9");
        run_checks();
        repeat (4) @(negedge clk);
        expect_b(0, 3, 8'h33, "R2");   // still present later in the frame
        expect_b(1, 5, 8'h55, "R3");
        run_checks();

        // R5: write coincident with the strobe.
        @(negedge clk);
        frame_stb = 1; mv_lt_we = 1; mv_lt_ch = 5'd9; mv_lt_wdata = 8'h77;
        @(negedge clk);
        frame_stb = 0; mv_lt_we = 0;

        // Frame A+2: old data gone, coincident write not yet out.
        expect_b(0, 3, 8'hFF, "R4");
        expect_b(1, 5, 8'hFF, "R4");
        expect_b(0, 9, 8'hFF, "R5");
        run_checks();
        strobe();
        expect_b(0, 9, 8'h77, "R5");
        run_checks();

        // R7: conference stage on.
        @(negedge clk);
        conf_en = 1;
        wr(0, 2, 8'hA5); wr(2, 2, 8'h5A); wr(1, 2, 8'hC3);
        strobe();
        expect_b(0, 2, 8'hFF, "R7");
        expect_b(2, 2, 8'hFF, "R7");
        expect_b(0, 9, 8'h77, "R7");   // previous frame's byte delayed by the hold bank
        expect_b(1, 2, 8'hC3, "R7");   // receive path unchanged
        run_checks();
        strobe();
        expect_b(0, 2, 8'hA5, "R7");
        expect_b(2, 2, 8'h5A, "R7");
        expect_b(1, 2, 8'hFF, "R7");
        run_checks();
        @(negedge clk);
        conf_en = 0;
        strobe();
        strobe();

        // R8: PCM receive to line transmit via mover copy.
        wr(3, 10, 8'h3C);              // frame 1: capture
        strobe();
        expect_b(3, 10, 8'h3C, "R8");  // frame 2: readable
        expect_b(0, 10, 8'hFF, "R8");
        run_checks();
        copied = mv_pr_rdata;
        wr(0, 10, copied);             // frame 2: mover copy
        strobe();
        expect_b(0, 10, 8'h3C, "R8");  // frame 3: transmitted
        expect_b(3, 10, 8'hFF, "R4");
        run_checks();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule